// File: doc/BRIEF.md
# Ping-Pong Descriptor Scanline Streamer

This block moves 32-bit words from a synchronous memory into a pixel FIFO. It is steered by a control list held in that same memory. The list is a run of two-word descriptors. The first word of each descriptor gives how many words to move, and the second word gives where the words start. After every descriptor the engine steps to the next one. A descriptor whose two words are both zero ends the list. At that point the engine raises a single-cycle interrupt and stops.

There are two control lists, and each has its own base-address input. The engine plays one list while software fills the other. Each time a list ends, the engine flips its bank index, so the next start pulse plays the other list. Each word is byte-reversed on its way to the output. The output handshake is valid/ready, and the engine holds a word for as long as the sink is not ready. An abort input stops everything on the next clock and leaves the engine idle.

Both lists normally begin with a single descriptor that points at a blanking/sync word pattern, followed by the zero terminator.

Top module: `scan_stream_engine`

## Requirements
- R1: A control list is a sequence of descriptors at word offsets 0, 2, 4, ... from the active list base. Word offset 2k holds the count, whose low CNT_W bits are used. Word offset 2k+1 holds the source word address, whose low AW bits are used. Descriptors are executed in list order.
- R2: For a descriptor with count N > 0 and address A, exactly N words are emitted, taken from addresses A, A+1, ..., A+N-1 in that order. The address wraps modulo 2^AW.
- R3: Every emitted word is the memory word with its four bytes reversed: bits [7:0] go out on [31:24], [15:8] on [23:16], [23:16] on [15:8], and [31:24] on [7:0].
- R4: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged. No word is lost or repeated because of stalls.
- R5: A descriptor with both words equal to zero ends the chain. irq_o then pulses high for exactly one cycle, only after the last word of the chain has been accepted. No other descriptor causes irq_o.
- R6: A descriptor with a zero count and a nonzero address emits nothing, and the walk continues with the next descriptor.
- R7: bank_o is 0 after reset. bank_o flips in the same cycle that irq_o is high and at no other time. A start pulse walks the list at list1_base_i when bank_o is 1, and the list at list0_base_i when bank_o is 0.
- R8: If the first descriptor of a list is the terminator, a start produces the interrupt and emits no data.
- R9: When abort_i is high, on the next cycle mem_req_o, out_valid_o and irq_o are all low. Buffered words are discarded and bank_o does not change. The engine stays idle until the next start, which walks the list again from its head.
- R10: A start pulse that arrives while a chain is in progress is ignored.
- R11: During reset and while idle after reset, out_valid_o, irq_o and mem_req_o are low and bank_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse: walk the list of the current bank |
| abort_i | input | 1 | Stop at once and return to idle |
| list0_base_i | input | AW | Word address of the bank-0 control list |
| list1_base_i | input | AW | Word address of the bank-1 control list |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a request |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Byte-reversed output word |
| out_ready_i | input | 1 | Sink accepts the word this cycle |
| irq_o | output | 1 | One-cycle end-of-chain interrupt |
| bank_o | output | 1 | Index of the list the next start plays |

## Verification
A lost or duplicated outstanding-read flag shows at the output within one or two cycles, as a dropped or doubled word in the captured stream. A stuck descriptor pointer or bank bit shows on the first descriptor fetch after start, because a wrong list is walked and the wrong words come out. An interrupt raised too early shows up as an interrupt arriving before the expected word count has been accepted. Stall handling is judged at every cycle in which the sink holds ready low, and abort is judged on the cycle after it.

// File: rtl/scan_stream_pkg.sv
package scan_stream_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CNT,
        ST_RD_ADR,
        ST_CHK,
        ST_STREAM,
        ST_FIN
    } sse_state_e;

endpackage

// File: rtl/scan_stream_swap.sv
module scan_stream_swap
    import scan_stream_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    localparam int NBYTES = W / BYTE_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign out_o[g*BYTE_W +: BYTE_W] = in_i[(NBYTES-1-g)*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/scan_stream_fifo.sv
module scan_stream_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, n;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        n = q;
        if (push_i) n.wp = adv(q.wp);
        if (pop_i)  n.rp = adv(q.rp);
        n.cnt = q.cnt + CW'(push_i) - CW'(pop_i);
        if (flush_i) n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i) mem_q[q.wp] <= data_i;
    end

    assign data_o  = mem_q[q.rp];
    assign count_o = q.cnt;

    // R4: a word is never pushed into a full buffer unless one leaves
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        push_i |-> ((q.cnt < CW'(DEPTH)) || pop_i));

    // R4: nothing is taken from an empty buffer
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        pop_i |-> (q.cnt != '0));

endmodule

// File: rtl/scan_stream_engine.sv
module scan_stream_engine
    import scan_stream_pkg::*;
#(
    parameter int AW         = 8,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [AW-1:0]     list0_base_i,
    input  logic [AW-1:0]     list1_base_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              irq_o,
    output logic              bank_o
);
    localparam int FCW = $clog2(FIFO_DEPTH+1);

    typedef struct packed {
        sse_state_e      st;
        logic            bank;
        logic [AW-1:0]   ptr;
        logic [AW-1:0]   rd_addr;
        logic [CNT_W-1:0] remain;
        logic            cnt_zero;
        logic            pend;
        logic            irq;
    } eng_t;

    localparam eng_t ENG_RST = '{ST_IDLE, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0};

    eng_t q, n;

    logic [WORD_W-1:0] swapped;
    logic [FCW-1:0]    fifo_cnt;
    logic              push, pop, issue, req_c;
    logic [AW-1:0]     addr_c, list_base;
    logic [FCW:0]      slots_used;

    scan_stream_swap #(.W(WORD_W)) u_swap (
        .in_i  (mem_rdata_i),
        .out_o (swapped)
    );

    assign out_valid_o = (fifo_cnt != '0);
    assign pop         = out_valid_o && out_ready_i;
    assign push        = q.pend;

    scan_stream_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (abort_i),
        .push_i  (push),
        .data_i  (swapped),
        .pop_i   (pop),
        .data_o  (out_data_o),
        .count_o (fifo_cnt)
    );

    assign list_base  = q.bank ? list1_base_i : list0_base_i;
    assign slots_used = {1'b0, fifo_cnt} + (FCW+1)'(q.pend) - (FCW+1)'(pop);
    assign issue      = (q.st == ST_STREAM) && (q.remain != '0)
                        && (slots_used < (FCW+1)'(FIFO_DEPTH));

    always_comb begin
        n      = q;
        n.irq  = 1'b0;
        n.pend = issue;
        req_c  = 1'b0;
        addr_c = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.ptr = '0;
                    n.st  = ST_RD_CNT;
                end
            end
            ST_RD_CNT: begin
                req_c  = 1'b1;
                addr_c = list_base + q.ptr;
                n.st   = ST_RD_ADR;
            end
            ST_RD_ADR: begin
                req_c      = 1'b1;
                addr_c     = list_base + q.ptr + AW'(1);
                n.remain   = mem_rdata_i[CNT_W-1:0];
                n.cnt_zero = (mem_rdata_i == '0);
                n.st       = ST_CHK;
            end
            ST_CHK: begin
                if (q.cnt_zero && (mem_rdata_i == '0)) begin
                    n.st = ST_FIN;
                end else if (q.remain == '0) begin
                    n.ptr = q.ptr + AW'(2);
                    n.st  = ST_RD_CNT;
                end else begin
                    n.rd_addr = mem_rdata_i[AW-1:0];
                    n.st      = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (issue) begin
                    req_c     = 1'b1;
                    addr_c    = q.rd_addr;
                    n.rd_addr = q.rd_addr + AW'(1);
                    n.remain  = q.remain - CNT_W'(1);
                end else if ((q.remain == '0) && !q.pend) begin
                    n.ptr = q.ptr + AW'(2);
                    n.st  = ST_RD_CNT;
                end
            end
            ST_FIN: begin
                if (fifo_cnt == '0) begin
                    n.irq  = 1'b1;
                    n.bank = ~q.bank;
                    n.st   = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (abort_i) begin
            n      = ENG_RST;
            n.bank = q.bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= n;
    end

    assign mem_req_o  = req_c && !abort_i;
    assign mem_addr_o = addr_c;
    assign irq_o      = q.irq;
    assign bank_o     = q.bank;

    // R5: the interrupt comes only once every word has left the block
    p_irq_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !out_valid_o);

    // R5: single-cycle interrupt
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: bank flips together with the interrupt
    p_bank_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bank_o != $past(bank_o)));

    // R7: bank holds at all other times
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (bank_o == $past(bank_o)));

    // R9: abort silences the engine on the next cycle
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!mem_req_o && !out_valid_o && !irq_o));

    // R4: a stalled word stays put
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !abort_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: tb/tb_scan_stream_engine.sv
`timescale 1ns/1ps
module tb_scan_stream_engine;
    localparam int AW = 8;
    localparam logic [7:0] L0 = 8'h00;
    localparam logic [7:0] L1 = 8'h10;

    // fields: count[31:24] address[23:16] stall mode[15:8] expected words[7:0]
    localparam logic [31:0] VEC [6] = '{
        32'h04_40_00_04,
        32'h01_50_01_01,
        32'h07_60_02_07,
        32'h00_70_00_00,
        32'h10_A0_01_10,
        32'h02_FE_02_02
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic abort_i = 1'b0;
    logic out_ready_i = 1'b0;
    logic mem_req_o, out_valid_o, irq_o, bank_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0] mem_rdata, out_data_o;

    logic [31:0] mem [0:255];
    logic [31:0] exp_w [0:63];
    logic [31:0] cap [0:63];
    int exp_n = 0, cap_n = 0, irq_n = 0, irq_at = -1;
    int total = 0, bad = 0;
    int cyc = 0, stall_mode = 0;
    logic cur_bank = 1'b0;
    logic prev_hold = 1'b0, prev_skip = 1'b1;
    logic [31:0] prev_data = '0;

    always #2 clk = ~clk;

    scan_stream_engine #(.AW(AW), .CNT_W(16), .FIFO_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .list0_base_i(L0), .list1_base_i(L1),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .irq_o(irq_o), .bank_o(bank_o)
    );

    always @(posedge clk) if (mem_req_o) mem_rdata <= mem[mem_addr_o];

    function automatic logic [31:0] pat(input int a);
        logic [7:0] b = a[7:0];
        return {b ^ 8'h5A, b, 8'hC3, ~b};
    endfunction

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // collector: ready pattern, stall check (R4), capture, interrupt log
    always @(negedge clk) begin
        cyc++;
        out_ready_i = (stall_mode == 0) || (cyc % (stall_mode + 1) == 0);
        if (prev_hold && !prev_skip)
            check(out_valid_o && (out_data_o == prev_data), "R4 stall hold", out_data_o, prev_data);
        prev_hold = out_valid_o && !out_ready_i;
        prev_data = out_data_o;
        prev_skip = abort_i || !rst_n;
        if (out_valid_o && out_ready_i && cap_n < 64) begin
            cap[cap_n] = out_data_o;
            cap_n++;
        end
        if (irq_o) begin
            if (irq_n == 0) irq_at = cap_n;
            irq_n++;
        end
    end

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic put_desc(input logic b, input int k, input logic [31:0] c, input logic [31:0] a);
        int base = int'(b ? L1 : L0);
        mem[base + 2*k]     = c;
        mem[base + 2*k + 1] = a;
        if (c[15:0] != 16'd0)
            for (int i = 0; i < int'(c[15:0]); i++)
                if (exp_n < 64) begin
                    exp_w[exp_n] = swp(pat(int'(a) + i));
                    exp_n++;
                end
    endtask

    task automatic new_chain();
        exp_n = 0;
        cap_n = 0;
        irq_n = 0;
        irq_at = -1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
    endtask

    task automatic finish_chain(input logic exp_bank);
        int guard = 0;
        int first_bad = -1;
        while (irq_n == 0 && guard < 3000) begin
            tick(1);
            guard++;
        end
        tick(20);
        check(irq_n == 1, "R5 one interrupt per chain", irq_n, 1);
        check(irq_at == exp_n, "R5 interrupt after last word", irq_at, exp_n);
        check(cap_n == exp_n, "R2 word count", cap_n, exp_n);
        for (int i = 0; i < cap_n && i < exp_n; i++)
            if (first_bad < 0 && cap[i] !== exp_w[i]) first_bad = i;
        check(first_bad < 0, "R3 byte-reversed data in order",
              (first_bad < 0) ? 32'd0 : cap[first_bad],
              (first_bad < 0) ? 32'd0 : exp_w[first_bad]);
        check(bank_o == exp_bank, "R7 bank after chain", bank_o, exp_bank);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        // both lists start out as one sync-pattern descriptor plus terminator
        put_desc(1'b0, 0, 32'd3, 32'h80);
        put_desc(1'b0, 1, 32'd0, 32'd0);
        put_desc(1'b1, 0, 32'd3, 32'h80);
        put_desc(1'b1, 1, 32'd0, 32'd0);

        // R11: reset state
        tick(3);
        check(!out_valid_o && !irq_o && !mem_req_o, "R11 quiet in reset",
              {out_valid_o, irq_o, mem_req_o}, 0);
        check(bank_o == 1'b0, "R11 bank in reset", bank_o, 0);
        rst_n = 1'b1;
        tick(4);
        check(!out_valid_o && !irq_o && !mem_req_o, "R11 idle after reset",
              {out_valid_o, irq_o, mem_req_o}, 0);

        // default lists in both banks: R7 ping-pong
        for (int b = 0; b < 2; b++) begin
            new_chain();
            put_desc(cur_bank, 0, 32'd3, 32'h80);
            put_desc(cur_bank, 1, 32'd0, 32'd0);
            pulse_start();
            cur_bank = ~cur_bank;
            finish_chain(cur_bank);
        end

        // table of single-descriptor chains (R2 R3 R4 R5 R6 R7)
        for (int v = 0; v < 6; v++) begin
            new_chain();
            stall_mode = int'(VEC[v][15:8]);
            put_desc(cur_bank, 0, {24'd0, VEC[v][31:24]}, {24'd0, VEC[v][23:16]});
            put_desc(cur_bank, 1, 32'd0, 32'd0);
            pulse_start();
            cur_bank = ~cur_bank;
            finish_chain(cur_bank);
            check(cap_n == int'(VEC[v][7:0]), "R2 table word count", cap_n, VEC[v][7:0]);
        end

        // R1 multi-descriptor walk, with R6 skipped zero-count entry
        new_chain();
        stall_mode = 1;
        put_desc(cur_bank, 0, 32'd2, 32'h40);
        put_desc(cur_bank, 1, 32'd0, 32'h33);
        put_desc(cur_bank, 2, 32'd3, 32'hC0);
        put_desc(cur_bank, 3, 32'd1, 32'h90);
        put_desc(cur_bank, 4, 32'd0, 32'd0);
        pulse_start();
        cur_bank = ~cur_bank;
        finish_chain(cur_bank);
        check(cap_n == 6, "R1 R6 list walk words", cap_n, 6);

        // R8 terminator first
        new_chain();
        stall_mode = 0;
        put_desc(cur_bank, 0, 32'd0, 32'd0);
        pulse_start();
        cur_bank = ~cur_bank;
        finish_chain(cur_bank);
        check(cap_n == 0 && irq_n == 1, "R8 empty chain", cap_n, 0);

        // R10 start while busy is ignored
        new_chain();
        stall_mode = 2;
        put_desc(cur_bank, 0, 32'd10, 32'h40);
        put_desc(cur_bank, 1, 32'd0, 32'd0);
        pulse_start();
        tick(6);
        pulse_start();
        cur_bank = ~cur_bank;
        finish_chain(cur_bank);
        check(cap_n == 10, "R10 busy start ignored", cap_n, 10);

        // R9 abort mid-stream
        new_chain();
        stall_mode = 1;
        put_desc(cur_bank, 0, 32'd20, 32'h40);
        put_desc(cur_bank, 1, 32'd0, 32'd0);
        pulse_start();
        tick(10);
        abort_i = 1'b1;
        tick(1);
        abort_i = 1'b0;
        check(!mem_req_o && !out_valid_o && !irq_o, "R9 quiet after abort",
              {mem_req_o, out_valid_o, irq_o}, 0);
        check(bank_o == cur_bank, "R9 bank kept", bank_o, cur_bank);
        tick(15);
        check(irq_n == 0 && !out_valid_o, "R9 stays idle", irq_n, 0);
        cap_n = 0;
        pulse_start();
        cur_bank = ~cur_bank;
        finish_chain(cur_bank);
        check(cap_n == 20, "R9 replay from list head", cap_n, 20);

        // R11 reset in the middle of a chain
        new_chain();
        stall_mode = 0;
        put_desc(cur_bank, 0, 32'd30, 32'h40);
        put_desc(cur_bank, 1, 32'd0, 32'd0);
        pulse_start();
        tick(8);
        rst_n = 1'b0;
        tick(1);
        check(!out_valid_o && !irq_o && !mem_req_o && !bank_o, "R11 reset mid-run",
              {out_valid_o, irq_o, mem_req_o, bank_o}, 0);
        tick(2);
        rst_n = 1'b1;
        irq_n = 0;
        tick(10);
        check(irq_n == 0 && !out_valid_o && !mem_req_o, "R11 idle after mid-run reset", irq_n, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule